// File: doc/BRIEF.md
# T1 Payload Loopback Multiplexer

This block sits in the bit-serial datapath of a T1/J1 framer, between the receive framer and the transmit framer. It takes a received bit stream that is already aligned to the 193-bit frame, together with a receive frame-start pulse, and a system-side transmit stream. It decides, bit by bit, what goes out toward the line and what goes to the system receive output. A frame has one framing slot at position 0, followed by 192 payload slots.

With payload loopback off, the line output carries the system transmit data in the payload slots and a locally generated framing bit in slot 0. With loopback on, the 192 received payload bits go back to the line and the system transmit input has no effect. Slot 0 is then filled either by the local framing bit (local mode) or by the received framing/data-link bit (transparent mode). Receive data still flows to the system side unchanged, unless a separate alarm control replaces it with a continuous all-ones alarm indication signal. Mode changes are picked up only in the slot-0 cycle, so a frame is never split between two modes. A small state machine holds the active mode. Its states are ST_NORMAL, ST_LOOP_LOCAL and ST_LOOP_TRANSP. In every slot-0 cycle it moves to ST_NORMAL when loopback is off, to ST_LOOP_LOCAL when loopback is on and transparency is off, and to ST_LOOP_TRANSP when both are on. In every other cycle it stays where it is.

Top module: `t1_payload_loop`

## Requirements
- R1: The slot position is 0 in any cycle where `rx_frame_start` is high. Otherwise it follows the previous position plus one and wraps from 192 to 0, so that slot 0 recurs every 193 bits without a pulse.
- R2: With the active mode normal, `line_tx_bit` in the cycle after a bit equals `loc_fbit` for slot 0 and `sys_tx_bit` for slots 1 to 192.
- R3: With either loopback mode active, `line_tx_bit` one clock after a payload slot (1 to 192) equals `rx_bit` of that slot, whatever `sys_tx_bit` carries.
- R4: In local loopback mode (`loop_en`=1, `transp_en`=0), `line_tx_bit` one clock after slot 0 equals `loc_fbit`.
- R5: In transparent loopback mode (`loop_en`=1, `transp_en`=1), `line_tx_bit` one clock after slot 0 equals the received `rx_bit`. With `loop_en`=0, `transp_en` has no effect.
- R6: `loop_en` and `transp_en` are sampled only in the slot-0 cycle. The mode chosen there applies to that whole frame, and changes in other slots have no effect until the next slot 0.
- R7: With `ais_en` low, `sys_rx_bit` equals `rx_bit` one clock later, in every mode, loopback included.
- R8: With `ais_en` high, `sys_rx_bit` is 1 one clock later in every slot, framing slot included, regardless of loopback.
- R9: While `rst_n` is low, `line_tx_bit` and `sys_rx_bit` are 0 and the active mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received, frame-aligned bit |
| rx_frame_start | input | 1 | High with the slot-0 bit of a received frame |
| sys_tx_bit | input | 1 | System-side transmit data |
| loc_fbit | input | 1 | Locally generated framing/CRC/data-link bit, used in slot 0 |
| loop_en | input | 1 | Payload loopback request |
| transp_en | input | 1 | Pass the received slot-0 bit through during loopback |
| ais_en | input | 1 | Force all ones onto the system receive output |
| line_tx_bit | output | 1 | Bit toward the line transmitter |
| sys_rx_bit | output | 1 | Bit toward the system receive side |

## Verification
The hardest case to reach from the ports is a mode request that changes in the middle of a frame. A block that sampled the request continuously would differ from a correct one only in the remaining slots of that frame. The frame task therefore flips `loop_en` or `transp_en` at a chosen slot partway through the frame, and predicts every bit with the mode latched at slot 0. A second hard case is slot 0 without a frame-start pulse. It is reached by running a frame with the pulse withheld, so the counter must wrap by itself, and by cutting a frame short with an early pulse.

// File: rtl/t1_loop_pkg.sv
package t1_loop_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL      = 2'd0,
        ST_LOOP_LOCAL  = 2'd1,
        ST_LOOP_TRANSP = 2'd2
    } loop_mode_e;

endpackage

// File: rtl/t1_slot_counter.sv
module t1_slot_counter #(
    parameter int PAYLOAD_BITS = 192,
    localparam int FRAME_BITS  = PAYLOAD_BITS + 1,
    localparam int CNT_W       = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    output logic [CNT_W-1:0] slot,
    output logic             at_slot0
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(PAYLOAD_BITS);

    logic [CNT_W-1:0] cnt_q;

    // the pulse forces slot 0; otherwise the registered count applies
    always_comb begin
        slot     = frame_start ? '0 : cnt_q;
        at_slot0 = (slot == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (slot == LAST_SLOT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= slot + 1'b1;
        end
    end

endmodule

// File: rtl/t1_mode_fsm.sv
module t1_mode_fsm
    import t1_loop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       at_slot0,
    input  logic       loop_en,
    input  logic       transp_en,
    output loop_mode_e state,
    output loop_mode_e eff_mode
);

    loop_mode_e req_mode;

    always_comb begin
        if (!loop_en) begin
            req_mode = ST_NORMAL;
        end else if (transp_en) begin
            req_mode = ST_LOOP_TRANSP;
        end else begin
            req_mode = ST_LOOP_LOCAL;
        end
    end

    // state register: moves only on a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
        end else if (at_slot0) begin
            state <= req_mode;
        end
    end

    // output process: mode governing the current bit
    always_comb begin
        unique case (state)
            ST_NORMAL,
            ST_LOOP_LOCAL,
            ST_LOOP_TRANSP: eff_mode = at_slot0 ? req_mode : state;
            default:        eff_mode = ST_NORMAL;
        endcase
    end

endmodule

// File: rtl/t1_tx_select.sv
module t1_tx_select
    import t1_loop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  loop_mode_e eff_mode,
    input  logic       at_slot0,
    input  logic       rx_bit,
    input  logic       sys_tx_bit,
    input  logic       loc_fbit,
    output logic       line_tx_bit
);

    logic tx_next;

    always_comb begin
        unique case (eff_mode)
            ST_NORMAL:      tx_next = at_slot0 ? loc_fbit : sys_tx_bit;
            ST_LOOP_LOCAL:  tx_next = at_slot0 ? loc_fbit : rx_bit;
            ST_LOOP_TRANSP: tx_next = rx_bit;
            default:        tx_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_tx_bit <= 1'b0;
        end else begin
            line_tx_bit <= tx_next;
        end
    end

endmodule

// File: rtl/t1_rx_alarm.sv
module t1_rx_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic ais_en,
    output logic sys_rx_bit
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rx_bit <= 1'b0;
        end else begin
            sys_rx_bit <= ais_en | rx_bit;
        end
    end

endmodule

// File: rtl/t1_payload_loop.sv
module t1_payload_loop
    import t1_loop_pkg::*;
#(
    parameter int PAYLOAD_BITS = 192,
    localparam int FRAME_BITS  = PAYLOAD_BITS + 1,
    localparam int CNT_W       = $clog2(FRAME_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_frame_start,
    input  logic sys_tx_bit,
    input  logic loc_fbit,
    input  logic loop_en,
    input  logic transp_en,
    input  logic ais_en,
    output logic line_tx_bit,
    output logic sys_rx_bit
);

    logic [CNT_W-1:0] slot;
    logic             at_slot0;
    loop_mode_e       state;
    loop_mode_e       eff_mode;

    t1_slot_counter #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (rx_frame_start),
        .slot        (slot),
        .at_slot0    (at_slot0)
    );

    t1_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_slot0  (at_slot0),
        .loop_en   (loop_en),
        .transp_en (transp_en),
        .state     (state),
        .eff_mode  (eff_mode)
    );

    t1_tx_select u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_mode    (eff_mode),
        .at_slot0    (at_slot0),
        .rx_bit      (rx_bit),
        .sys_tx_bit  (sys_tx_bit),
        .loc_fbit    (loc_fbit),
        .line_tx_bit (line_tx_bit)
    );

    t1_rx_alarm u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .ais_en     (ais_en),
        .sys_rx_bit (sys_rx_bit)
    );

endmodule

// File: rtl/t1_payload_loop_chk.sv
module t1_payload_loop_chk
    import t1_loop_pkg::*;
#(
    parameter int PAYLOAD_BITS = 192,
    localparam int CNT_W       = $clog2(PAYLOAD_BITS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_bit,
    input logic             rx_frame_start,
    input logic             sys_tx_bit,
    input logic             loc_fbit,
    input logic             loop_en,
    input logic             transp_en,
    input logic             ais_en,
    input logic             line_tx_bit,
    input logic             sys_rx_bit,
    input logic [CNT_W-1:0] slot,
    input loop_mode_e       state
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAYLOAD_BITS);

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == LAST && !rx_frame_start) |=> (rx_frame_start || slot == '0));

    a_r1_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_start |-> (slot == '0));

    a_r2_normal_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && slot != '0) |=> (line_tx_bit == $past(sys_tx_bit)));

    a_r3_loop_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_NORMAL && slot != '0) |=> (line_tx_bit == $past(rx_bit)));

    a_r4_local_fbit: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == '0 && loop_en && !transp_en) |=> (line_tx_bit == $past(loc_fbit)));

    a_r5_transp_fbit: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == '0 && loop_en && transp_en) |=> (line_tx_bit == $past(rx_bit)));

    a_r6_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != '0) |=> $stable(state));

    a_r7_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !ais_en |=> (sys_rx_bit == $past(rx_bit)));

    a_r8_ais_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ais_en |=> sys_rx_bit);

endmodule

bind t1_payload_loop t1_payload_loop_chk #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_bit         (rx_bit),
    .rx_frame_start (rx_frame_start),
    .sys_tx_bit     (sys_tx_bit),
    .loc_fbit       (loc_fbit),
    .loop_en        (loop_en),
    .transp_en      (transp_en),
    .ais_en         (ais_en),
    .line_tx_bit    (line_tx_bit),
    .sys_rx_bit     (sys_rx_bit),
    .slot           (slot),
    .state          (state)
);

// File: tb/t1_payload_loop_tb.sv
module t1_payload_loop_tb;

    localparam int NBITS = 193;

    logic clk = 1'b0;
    logic rst_n, rx_bit, rx_frame_start, sys_tx_bit, loc_fbit;
    logic loop_en, transp_en, ais_en;
    logic line_tx_bit, sys_rx_bit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    t1_payload_loop u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_bit         (rx_bit),
        .rx_frame_start (rx_frame_start),
        .sys_tx_bit     (sys_tx_bit),
        .loc_fbit       (loc_fbit),
        .loop_en        (loop_en),
        .transp_en      (transp_en),
        .ais_en         (ais_en),
        .line_tx_bit    (line_tx_bit),
        .sys_rx_bit     (sys_rx_bit)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // One frame of nbits bits. Mode inputs at slot 0 are lp/tp; at bit chg_at
    // (if >0) they switch to lp2/tp2, which must not matter (R6).
    task automatic run_frame(input string req, input bit pulse, input int nbits,
                             input bit lp, input bit tp, input bit ais,
                             input int chg_at, input bit lp2, input bit tp2);
        int  line_bad = 0, rx_bad = 0;
        int  line_got = 0, line_exp = 0, rx_got = 0, rx_exp = 0;
        bit  mlp = lp, mtp = tp;
        for (int i = 0; i < nbits; i++) begin
            bit exp_line, exp_rx;
            @(negedge clk);
            rx_bit         = 1'($urandom);
            sys_tx_bit     = 1'($urandom);
            loc_fbit       = 1'($urandom);
            rx_frame_start = pulse && (i == 0);
            ais_en         = ais;
            if (chg_at > 0 && i >= chg_at) begin
                loop_en = lp2; transp_en = tp2;
            end else begin
                loop_en = lp; transp_en = tp;
            end
            if (!mlp)           exp_line = (i == 0) ? loc_fbit : sys_tx_bit;
            else if (i != 0)    exp_line = rx_bit;
            else if (mtp)       exp_line = rx_bit;
            else                exp_line = loc_fbit;
            exp_rx = ais ? 1'b1 : rx_bit;
            @(posedge clk);
            #1;
            if (line_tx_bit !== exp_line && line_bad == 0) begin
                line_got = int'(line_tx_bit); line_exp = int'(exp_line);
                $display("  line mismatch at slot %0d", i);
            end
            if (line_tx_bit !== exp_line) line_bad++;
            if (sys_rx_bit !== exp_rx && rx_bad == 0) begin
                rx_got = int'(sys_rx_bit); rx_exp = int'(exp_rx);
                $display("  sys rx mismatch at slot %0d", i);
            end
            if (sys_rx_bit !== exp_rx) rx_bad++;
        end
        rx_frame_start = 1'b0;
        check(req, "line_tx_bit frame", line_got, line_exp);
        check(req, "sys_rx_bit frame", rx_got, rx_exp);
        check(req, "mismatching bits", line_bad + rx_bad, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; rx_bit = 1'b1; rx_frame_start = 1'b0; sys_tx_bit = 1'b1;
        loc_fbit = 1'b1; loop_en = 1'b1; transp_en = 1'b1; ais_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R9", "line_tx_bit in reset", int'(line_tx_bit), 0);
        check("R9", "sys_rx_bit in reset", int'(sys_rx_bit), 0);
        @(negedge clk);
        loop_en = 1'b0; transp_en = 1'b0; ais_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_normal;
        run_frame("R2", 1, NBITS, 0, 0, 0, 0, 0, 0);
        run_frame("R5_transp_ignored", 1, NBITS, 0, 1, 0, 0, 0, 1);
    endtask

    task automatic t_loop_local;
        run_frame("R3_R4", 1, NBITS, 1, 0, 0, 0, 1, 0);
        run_frame("R7_rx_during_loop", 1, NBITS, 1, 0, 0, 0, 1, 0);
    endtask

    task automatic t_loop_transp;
        run_frame("R5", 1, NBITS, 1, 1, 0, 0, 1, 1);
    endtask

    task automatic t_ais;
        run_frame("R8_noloop", 1, NBITS, 0, 0, 1, 0, 0, 0);
        run_frame("R8_loop", 1, NBITS, 1, 1, 1, 0, 1, 1);
    endtask

    task automatic t_midframe;
        run_frame("R6_on_mid", 1, NBITS, 0, 0, 0, 40, 1, 0);
        run_frame("R6_off_mid", 1, NBITS, 1, 0, 0, 100, 0, 0);
        run_frame("R6_transp_mid", 1, NBITS, 1, 0, 0, 7, 1, 1);
    endtask

    task automatic t_counter;
        run_frame("R1_pulse", 1, NBITS, 1, 0, 0, 0, 1, 0);
        run_frame("R1_wrap_nopulse", 0, NBITS, 1, 1, 0, 0, 1, 1);
        run_frame("R1_short", 1, 60, 0, 0, 0, 0, 0, 0);
        run_frame("R1_resync", 1, NBITS, 1, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_loop_local();
        t_loop_transp();
        t_ais();
        t_midframe();
        t_counter();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule